// File: doc/BRIEF.md
# Shared Bus Arbiter for DMA, Refresh and CPU

This block decides which master drives a shared system bus. It serves a memory refresh requester, a set of DMA channels (four by default) and the CPU. The CPU is the default owner. Each DMA channel request only counts while that channel's enable input is high. Refresh outranks every DMA channel, and the channels rank by index, with the lowest index first.

A new owner is chosen only at an arbitration point. An arbitration point is a clock edge where the bus is idle or where the current CPU or DMA cycle is in its final state. Between such points the grant outputs hold their value.

A two-cycle DMA transfer reads its source first and writes its destination second. Between the two halves, bus timing logic raises a gap flag. While that flag is high, only refresh may cut in. Otherwise the bus goes straight back to the channel that owns the pending write half, even when higher-ranked channels or the CPU are asking.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), and after it is released, the grant outputs show CPU ownership: gnt_cpu=1, gnt_rfsh=0, gnt_ch=0.
- R2: Exactly one of gnt_cpu, gnt_rfsh and the bits of gnt_ch is high in every cycle.
- R3: An arbitration point is a rising clock edge with bus_idle or xfer_last high. At any other edge the grants keep their value. A new decision shows on the grant outputs one clock after the arbitration-point edge.
- R4: At an arbitration point with rfsh_req high, refresh is granted. This holds whatever the DMA requests are and whether rw_gap is high or low.
- R5: With rw_gap low and no refresh request, the eligible DMA channel with the lowest index wins. Winning channel i raises gnt_ch bit i.
- R6: A channel whose ch_en bit is low is never granted from its ch_req bit, whatever that bit's value.
- R7: With rw_gap low, no refresh request and no eligible DMA request, the CPU is granted at an arbitration point.
- R8: At an arbitration point with rw_gap high and rfsh_req low, the grant goes to the owner channel. The owner channel is the DMA channel most recently granted. This holds whatever the ch_req and ch_en values are.
- R9: When refresh has been inserted inside a gap, the next arbitration point with rw_gap still high and rfsh_req low returns the bus to the same owner channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_req | input | 1 | Memory refresh request |
| ch_req | input | NUM_CH | DMA channel requests, bit i = channel i |
| ch_en | input | NUM_CH | DMA channel enables, bit i = channel i |
| bus_idle | input | 1 | Bus has no cycle in progress |
| xfer_last | input | 1 | Current CPU or DMA cycle is in its final state |
| rw_gap | input | 1 | Between read and write halves of a two-cycle DMA transfer |
| gnt_ch | output | NUM_CH | One-hot DMA channel grant |
| gnt_rfsh | output | 1 | Refresh grant |
| gnt_cpu | output | 1 | CPU grant |

## Verification
A corrupted source or channel register inside the arbiter shows on the grant outputs in the very next cycle. A wrong grant can be two-hot, empty, or on a channel nobody asked for. A stale owner register stays hidden until the next gap. It then appears as a write half given to the wrong channel one clock after the arbitration point inside that gap. For this reason the stimulus first moves ownership away from channel 0 before it opens a gap. A wrong arbitration-point decode shows as grants that move while the bus is busy, or that do not move when it is idle. The stimulus therefore alternates busy cycles with idle ones and with final-state cycles.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Which kind of master currently owns the bus
  typedef enum logic [1:0] {
    SRC_CPU  = 2'd0,
    SRC_RFSH = 2'd1,
    SRC_DMA  = 2'd2
  } src_e;

  // An edge is a decision point when the bus is free or a cycle ends
  function automatic logic is_arb_point(input logic idle, input logic last);
    return idle | last;
  endfunction

  // Pick the next owner kind from the request picture
  function automatic src_e pick_src(input logic rfsh, input logic gap,
                                    input logic any_dma);
    if (rfsh)
      return SRC_RFSH;
    else if (gap || any_dma)
      return SRC_DMA;
    else
      return SRC_CPU;
  endfunction

endpackage

// File: rtl/arb_req_mask.sv
module arb_req_mask #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] en,
  output logic [N-1:0] eligible
);
  for (genvar g = 0; g < N; g++) begin : g_mask
    assign eligible[g] = req[g] & en[g];
  end
endmodule

// File: rtl/arb_prio_enc.sv
module arb_prio_enc #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  // Lowest set index wins: scan downward so the last hit is the lowest
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/arb_owner_track.sv
module arb_owner_track #(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] idx_in,
  output logic [IW-1:0] owner
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      owner <= '0;
    else if (load)
      owner <= idx_in;
  end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rfsh_req,
  input  logic [NUM_CH-1:0] ch_req,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              bus_idle,
  input  logic              xfer_last,
  input  logic              rw_gap,
  output logic [NUM_CH-1:0] gnt_ch,
  output logic              gnt_rfsh,
  output logic              gnt_cpu
);
  import arb_pkg::*;

  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // Named internal events
  logic              arb_pt;
  logic [NUM_CH-1:0] eligible;
  logic              win_any;
  logic [IW-1:0]     win_idx;
  logic [IW-1:0]     owner;
  src_e              next_src;
  logic [IW-1:0]     next_idx;
  logic              owner_load;

  src_e              src_q;
  logic [IW-1:0]     idx_q;

  assign arb_pt = is_arb_point(bus_idle, xfer_last);

  arb_req_mask #(.N(NUM_CH)) i_mask (
    .req      (ch_req),
    .en       (ch_en),
    .eligible (eligible)
  );

  arb_prio_enc #(.N(NUM_CH), .IW(IW)) i_enc (
    .vec (eligible),
    .any (win_any),
    .idx (win_idx)
  );

  // Inside a gap the pending write half keeps its channel
  always_comb begin
    next_src = pick_src(rfsh_req, rw_gap, win_any);
    next_idx = rw_gap ? owner : win_idx;
  end

  assign owner_load = arb_pt && (next_src == SRC_DMA);

  arb_owner_track #(.IW(IW)) i_owner (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (owner_load),
    .idx_in (next_idx),
    .owner  (owner)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_CPU;
      idx_q <= '0;
    end else if (arb_pt) begin
      src_q <= next_src;
      idx_q <= next_idx;
    end
  end

  assign gnt_cpu  = (src_q == SRC_CPU);
  assign gnt_rfsh = (src_q == SRC_RFSH);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign gnt_ch[g] = (src_q == SRC_DMA) && (idx_q == IW'(g));
  end

endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rfsh_req,
  input logic [NUM_CH-1:0] ch_req,
  input logic [NUM_CH-1:0] ch_en,
  input logic              rw_gap,
  input logic              arb_pt,
  input logic [NUM_CH-1:0] gnt_ch,
  input logic              gnt_rfsh,
  input logic              gnt_cpu
);
  a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gnt_ch, gnt_rfsh, gnt_cpu}) == 1);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_pt |=> $stable({gnt_ch, gnt_rfsh, gnt_cpu}));

  a_r4_refresh_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && rfsh_req) |=> gnt_rfsh);

  a_r6_no_masked_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && !rw_gap) |=> ((gnt_ch & ~$past(ch_req & ch_en)) == '0));

  a_r7_cpu_default: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && !rw_gap && !rfsh_req && ((ch_req & ch_en) == '0)) |=> gnt_cpu);

  a_r8_gap_dma_only: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && rw_gap && !rfsh_req) |=> ($countones(gnt_ch) == 1));
endmodule

bind bus_arbiter bus_arbiter_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rfsh_req (rfsh_req),
  .ch_req   (ch_req),
  .ch_en    (ch_en),
  .rw_gap   (rw_gap),
  .arb_pt   (arb_pt),
  .gnt_ch   (gnt_ch),
  .gnt_rfsh (gnt_rfsh),
  .gnt_cpu  (gnt_cpu)
);

// File: tb/test_bus_arbiter.sv
module test_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rfsh_req = 1'b0;
  logic [3:0] ch_req = '0;
  logic [3:0] ch_en = '0;
  logic       bus_idle = 1'b0;
  logic       xfer_last = 1'b0;
  logic       rw_gap = 1'b0;
  logic [3:0] gnt_ch;
  logic       gnt_rfsh;
  logic       gnt_cpu;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_arbiter i_bus_arbiter (
    .clk (clk), .rst_n (rst_n), .rfsh_req (rfsh_req), .ch_req (ch_req),
    .ch_en (ch_en), .bus_idle (bus_idle), .xfer_last (xfer_last),
    .rw_gap (rw_gap), .gnt_ch (gnt_ch), .gnt_rfsh (gnt_rfsh), .gnt_cpu (gnt_cpu)
  );

  // {rf, req[3:0], en[3:0], idle, last, gap, exp{ch[3:0], rfsh, cpu}}
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 4'b0010, 4'b1111, 1'b1, 1'b0, 1'b0, 6'b001000},
    {1'b0, 4'b0011, 4'b1111, 1'b0, 1'b0, 1'b0, 6'b001000},
    {1'b0, 4'b0011, 4'b1111, 1'b0, 1'b1, 1'b0, 6'b000100},
    {1'b0, 4'b0011, 4'b1110, 1'b0, 1'b1, 1'b0, 6'b001000},
    {1'b0, 4'b1100, 4'b1111, 1'b1, 1'b0, 1'b0, 6'b010000},
    {1'b1, 4'b1111, 4'b1111, 1'b1, 1'b0, 1'b0, 6'b000010},
    {1'b0, 4'b0000, 4'b1111, 1'b1, 1'b0, 1'b0, 6'b000001},
    {1'b0, 4'b1000, 4'b1111, 1'b1, 1'b0, 1'b0, 6'b100000},
    {1'b0, 4'b0001, 4'b1111, 1'b0, 1'b1, 1'b1, 6'b100000},
    {1'b1, 4'b0001, 4'b1111, 1'b0, 1'b1, 1'b1, 6'b000010},
    {1'b0, 4'b0001, 4'b1111, 1'b0, 1'b1, 1'b1, 6'b100000},
    {1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 6'b000001},
    {1'b0, 4'b1111, 4'b0000, 1'b1, 1'b0, 1'b0, 6'b000001},
    {1'b0, 4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0, 6'b000001}
  };

  localparam string TAG [NV] = '{
    "R5", "R3", "R5", "R6", "R5", "R4", "R7",
    "R5", "R8", "R4", "R9", "R7", "R6", "R3"
  };

  function automatic logic [5:0] grants();
    return {gnt_ch, gnt_rfsh, gnt_cpu};
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: grants actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_one_hot();
    n_cmp++;
    if ($countones(grants()) != 1) begin
      n_bad++;
      $display("FAIL R2: grants actual %b expected one-hot", grants());
    end
  endtask

  task automatic apply(input logic [17:0] v);
    rfsh_req  = v[17];
    ch_req    = v[16:13];
    ch_en     = v[12:9];
    bus_idle  = v[8];
    xfer_last = v[7];
    rw_gap    = v[6];
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state, with requests present
    bus_idle = 1'b1;
    ch_req = 4'b1111;
    ch_en = 4'b1111;
    repeat (2) @(negedge clk);
    check("R1", grants(), 6'b000001);
    @(negedge clk);
    bus_idle = 1'b0;
    ch_req = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", grants(), 6'b000001);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      apply(VEC[k]);
      @(negedge clk);
      check(TAG[k], grants(), VEC[k][5:0]);
      check_one_hot();
    end

    // R8: gap grants owner even with its enable and request low
    @(negedge clk);
    apply({1'b0, 4'b0100, 4'b1111, 1'b1, 1'b0, 1'b0, 6'b0});
    @(negedge clk);
    check("R5", grants(), 6'b010000);
    apply({1'b0, 4'b0011, 4'b0011, 1'b0, 1'b1, 1'b1, 6'b0});
    @(negedge clk);
    check("R8", grants(), 6'b010000);

    // R3: busy cycles keep the grant while requests change
    apply({1'b1, 4'b0001, 4'b1111, 1'b0, 1'b0, 1'b0, 6'b0});
    repeat (3) @(negedge clk);
    check("R3", grants(), 6'b010000);

    // R1: asynchronous reset from a DMA grant
    #(CLK_PERIOD / 4) rst_n = 1'b0;
    #1;
    check("R1", grants(), 6'b000001);
    @(negedge clk);
    rst_n = 1'b1;
    apply({1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 6'b0});
    @(negedge clk);
    check("R1", grants(), 6'b000001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule